// File: doc/BRIEF.md
# Status-Qualified Halt Clock Stopper

This block sits beside a clock generator. It watches the three status lines of a processor and decides when the system clocks may be stopped. A halt code on the status lines is trusted only when it comes directly after the passive, no-bus-cycle code. The status lines can pass through arbitrary codes while a bus cycle ends, and this rule keeps such a stray halt code from stopping the system.

The status lines pass through a synchronizer. They are then sampled once per main-clock period, and the block derives that period from the oscillator-rate clock it runs on. When a halt is recognized, the block freezes the peripheral clock at once. It then drops the main-clock enable a fixed number of main-clock periods later, so the main clock and its 50%-duty companion come to rest high. The stop is applied through one of two enables, chosen by a mode input: one halts the oscillator and the other gates only the internal clock path.

The top status line also works as a stop line on its own. With the two lower lines held high, pulling it from high to low forms the passive-then-halt pair. A start command clears a stop at any time. After a start or a reset, the block needs a new passive-then-halt pair before it will stop again.

Top module: `halt_clock_gate`

## Requirements
- R1: During and after reset, main_en_o=1, pclk_freeze_o=0, osc_run_o=1 and gate_en_o=1, and the qualifier waits for a passive code.
- R2: status_i is read as {stop/s2, s1, s0}. When a 3'b111 sample is followed by a 3'b011 sample on the next main-clock sample, pclk_freeze_o goes to 1.
- R3: A 3'b011 sample that does not directly follow a 3'b111 sample (for example after 3'b010 or 3'b101) causes no stop. All outputs keep their running values.
- R4: pclk_freeze_o rises while main_en_o is still 1, so the peripheral clock freezes at its current level before the main clock stops.
- R5: main_en_o falls to 0 STOP_DELAY (default 2) main-clock ticks after the halt is recognized. It then stays 0 until a start command.
- R6: With s1 and s0 held at 1, holding the stop line at 1 for at least one main-clock period and then driving it to 0 produces a stop.
- R7: A start_i pulse of one clock returns main_en_o to 1 and pclk_freeze_o to 0 on the next clock, even while the stop line is still low.
- R8: After a start, a status of 3'b011 held from before the start causes no stop. Only a new 3'b111 followed by 3'b011 stops the clocks again.
- R9: While stopped, mode_i=0 drives osc_run_o=0 with gate_en_o=1, and mode_i=1 drives gate_en_o=0 with osc_run_o=1. While running, both are 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator-rate clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Start command, synchronous, overrides any stop |
| status_i | input | 3 | Processor status {stop/s2, s1, s0}, asynchronous |
| mode_i | input | 1 | Stop mode: 0 halts the oscillator, 1 gates the clock path |
| main_en_o | output | 1 | Enable for the main clock and its 50% companion (0 = held high) |
| pclk_freeze_o | output | 1 | Freezes the peripheral clock at its present level |
| osc_run_o | output | 1 | Oscillator run enable (stop-oscillator mode) |
| gate_en_o | output | 1 | Internal clock-path enable (stop-clock mode) |

## Verification
The bench sends halt codes that follow non-passive codes, and a passive code with an intervening code before the halt. A qualifier that accepted any 3'b011 would stop the clocks in those cases. It pulses start while the stop line is still held low and then waits many periods. A block that did not re-arm would stop again at once, and one that failed to override would stay frozen. It also checks that the freeze comes before the main enable drops, and that each stop mode clears only its own enable. A behavioural model is compared with the outputs on every clock, so an off-by-one in the drain delay or in the sampling phase shows up at once.

// File: rtl/hcg_pkg.sv
package hcg_pkg;

    typedef logic [2:0] status_t;

    localparam status_t ST_PASSIVE = 3'b111;
    localparam status_t ST_HALT    = 3'b011;

    typedef enum logic [1:0] {
        Q_WAIT_PASSIVE = 2'd0,
        Q_SAW_PASSIVE  = 2'd1,
        Q_HALTED       = 2'd2
    } qual_state_e;

    typedef enum logic [1:0] {
        S_RUN     = 2'd0,
        S_DRAIN   = 2'd1,
        S_STOPPED = 2'd2
    } stop_state_e;

endpackage

// File: rtl/hcg_sync.sv
module hcg_sync #(
    parameter int WIDTH  = 3,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_i,
    output logic [WIDTH-1:0] sync_o
);
    logic [WIDTH-1:0] stage_q [STAGES];

    genvar g;
    generate
        for (g = 0; g < STAGES; g++) begin : g_stage
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    stage_q[g] <= '0;
                end else if (g == 0) begin
                    stage_q[g] <= async_i;
                end else begin
                    stage_q[g] <= stage_q[(g == 0) ? 0 : g - 1];
                end
            end
        end
    endgenerate

    assign sync_o = stage_q[STAGES-1];
endmodule

// File: rtl/hcg_tick.sv
module hcg_tick #(
    parameter int PERIOD = 3
) (
    input  logic clk,
    input  logic rst_n,
    output logic tick_o
);
    generate
        if (PERIOD <= 1) begin : g_every
            assign tick_o = 1'b1;
        end else begin : g_count
            localparam int CW = $clog2(PERIOD);
            localparam logic [CW-1:0] LAST = CW'(PERIOD - 1);

            logic [CW-1:0] cnt_d, cnt_q;

            always_comb begin
                cnt_d = cnt_q + 1'b1;
                if (cnt_q == LAST) begin
                    cnt_d = '0;
                end
            end

            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    cnt_q <= '0;
                end else begin
                    cnt_q <= cnt_d;
                end
            end

            assign tick_o = (cnt_q == LAST);
        end
    endgenerate
endmodule

// File: rtl/hcg_qualifier.sv
module hcg_qualifier
    import hcg_pkg::*;
(
    input  logic    clk,
    input  logic    rst_n,
    input  logic    start_i,
    input  logic    tick_i,
    input  status_t status_i,
    output logic    halted_o
);
    typedef struct packed {
        qual_state_e st;
    } qual_regs_t;

    qual_regs_t r_d, r_q;

    always_comb begin
        r_d = r_q;
        if (start_i) begin
            r_d.st = Q_WAIT_PASSIVE;
        end else if (tick_i) begin
            unique case (r_q.st)
                Q_HALTED: r_d.st = Q_HALTED;
                Q_SAW_PASSIVE: begin
                    if (status_i == ST_PASSIVE)   r_d.st = Q_SAW_PASSIVE;
                    else if (status_i == ST_HALT) r_d.st = Q_HALTED;
                    else                          r_d.st = Q_WAIT_PASSIVE;
                end
                default: begin
                    if (status_i == ST_PASSIVE) r_d.st = Q_SAW_PASSIVE;
                    else                        r_d.st = Q_WAIT_PASSIVE;
                end
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q.st <= Q_WAIT_PASSIVE;
        end else begin
            r_q <= r_d;
        end
    end

    assign halted_o = (r_q.st == Q_HALTED);
endmodule

// File: rtl/hcg_stop_ctrl.sv
module hcg_stop_ctrl
    import hcg_pkg::*;
#(
    parameter int STOP_DELAY = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start_i,
    input  logic tick_i,
    input  logic halted_i,
    input  logic mode_i,
    output logic main_en_o,
    output logic osc_run_o,
    output logic gate_en_o
);
    localparam int CW = $clog2(STOP_DELAY) + 1;
    localparam logic [CW-1:0] LAST = CW'(STOP_DELAY - 1);

    typedef struct packed {
        stop_state_e   st;
        logic [CW-1:0] cnt;
    } stop_regs_t;

    stop_regs_t r_d, r_q;

    always_comb begin
        r_d = r_q;
        if (start_i) begin
            r_d.st  = S_RUN;
            r_d.cnt = '0;
        end else begin
            unique case (r_q.st)
                S_RUN: begin
                    if (halted_i) begin
                        r_d.st  = S_DRAIN;
                        r_d.cnt = '0;
                    end
                end
                S_DRAIN: begin
                    if (tick_i) begin
                        if (r_q.cnt == LAST) r_d.st = S_STOPPED;
                        else                 r_d.cnt = r_q.cnt + 1'b1;
                    end
                end
                default: r_d.st = S_STOPPED;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q.st  <= S_RUN;
            r_q.cnt <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    logic stopped;
    assign stopped   = (r_q.st == S_STOPPED);
    assign main_en_o = !stopped;
    assign osc_run_o = !(stopped && !mode_i);
    assign gate_en_o = !(stopped && mode_i);
endmodule

// File: rtl/halt_clock_gate.sv
module halt_clock_gate
    import hcg_pkg::*;
#(
    parameter int OSC_PER_MAIN = 3,
    parameter int STOP_DELAY   = 2,
    parameter int SYNC_STAGES  = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start_i,
    input  logic [2:0] status_i,
    input  logic       mode_i,
    output logic       main_en_o,
    output logic       pclk_freeze_o,
    output logic       osc_run_o,
    output logic       gate_en_o
);
    status_t status_sync;
    logic    tick;
    logic    halted;

    hcg_sync #(.WIDTH(3), .STAGES(SYNC_STAGES)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i (status_i),
        .sync_o  (status_sync)
    );

    hcg_tick #(.PERIOD(OSC_PER_MAIN)) u_tick (
        .clk    (clk),
        .rst_n  (rst_n),
        .tick_o (tick)
    );

    hcg_qualifier u_qual (
        .clk      (clk),
        .rst_n    (rst_n),
        .start_i  (start_i),
        .tick_i   (tick),
        .status_i (status_sync),
        .halted_o (halted)
    );

    hcg_stop_ctrl #(.STOP_DELAY(STOP_DELAY)) u_stop (
        .clk       (clk),
        .rst_n     (rst_n),
        .start_i   (start_i),
        .tick_i    (tick),
        .halted_i  (halted),
        .mode_i    (mode_i),
        .main_en_o (main_en_o),
        .osc_run_o (osc_run_o),
        .gate_en_o (gate_en_o)
    );

    assign pclk_freeze_o = halted;
endmodule

// File: rtl/hcg_checker.sv
module hcg_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       start_i,
    input logic [2:0] status_i,
    input logic       mode_i,
    input logic       main_en_o,
    input logic       pclk_freeze_o,
    input logic       osc_run_o,
    input logic       gate_en_o
);
    // R1: reset leaves the clocks running and unfrozen
    a_r1_reset_runs: assert property (@(posedge clk)
        !rst_n |=> (main_en_o && !pclk_freeze_o));

    // R4: main enable only drops while the peripheral clock is frozen
    a_r4_freeze_first: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(main_en_o) |-> (pclk_freeze_o && $past(pclk_freeze_o)));

    // R5: once stopped, the main enable stays low until a start
    a_r5_stays_stopped: assert property (@(posedge clk) disable iff (!rst_n)
        (!main_en_o && !start_i) |=> !main_en_o);

    // R7: start releases everything on the next clock
    a_r7_start_release: assert property (@(posedge clk) disable iff (!rst_n)
        start_i |=> (main_en_o && !pclk_freeze_o));

    // R2: a new freeze never follows a start cycle
    a_r2_no_freeze_on_start: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pclk_freeze_o) |-> !$past(start_i));

    // R9: each stop mode clears only its own enable
    a_r9_mode_split: assert property (@(posedge clk) disable iff (!rst_n)
        !(osc_run_o == 1'b0 && gate_en_o == 1'b0));

    a_r9_running_enables: assert property (@(posedge clk) disable iff (!rst_n)
        main_en_o |-> (osc_run_o && gate_en_o));

    logic unused_ok;
    assign unused_ok = ^{status_i, mode_i};
endmodule

bind halt_clock_gate hcg_checker i_hcg_checker (
    .clk           (clk),
    .rst_n         (rst_n),
    .start_i       (start_i),
    .status_i      (status_i),
    .mode_i        (mode_i),
    .main_en_o     (main_en_o),
    .pclk_freeze_o (pclk_freeze_o),
    .osc_run_o     (osc_run_o),
    .gate_en_o     (gate_en_o)
);

// File: tb/test_halt_clock_gate.sv
`timescale 1ns/1ps
module test_halt_clock_gate;
    localparam int N     = 3;
    localparam int DELAY = 2;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start_i = 1'b0;
    logic [2:0] status_i = 3'b000;
    logic       mode_i = 1'b0;
    logic       main_en_o, pclk_freeze_o, osc_run_o, gate_en_o;

    int total = 0;
    int bad   = 0;
    int cyc   = 0;

    always #4 clk = ~clk;

    halt_clock_gate #(.OSC_PER_MAIN(N), .STOP_DELAY(DELAY), .SYNC_STAGES(2)) i_halt_clock_gate (
        .clk           (clk),
        .rst_n         (rst_n),
        .start_i       (start_i),
        .status_i      (status_i),
        .mode_i        (mode_i),
        .main_en_o     (main_en_o),
        .pclk_freeze_o (pclk_freeze_o),
        .osc_run_o     (osc_run_o),
        .gate_en_o     (gate_en_o)
    );

    task automatic check(input string what, input logic got, input logic exp);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s: got %b expected %b (cycle %0d)", what, got, exp, cyc);
        end
    endtask

    // behavioural reference model
    int m_phase, m_stop, m_drain;
    logic [2:0] m_pipe [$];
    bit m_armed, m_halt;

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_phase = 0; m_stop = 0; m_drain = 0;
            m_armed = 0; m_halt = 0;
            m_pipe = {3'b000, 3'b000};
        end else begin
            bit tk, old_halt;
            logic [2:0] seen;
            tk = (m_phase == N - 1);
            m_phase = tk ? 0 : m_phase + 1;
            seen = m_pipe.pop_front();
            m_pipe.push_back(status_i);
            old_halt = m_halt;
            if (start_i) begin
                m_armed = 0; m_halt = 0; m_stop = 0; m_drain = 0;
            end else begin
                if (m_stop == 0 && old_halt) begin
                    m_stop = 1; m_drain = 0;
                end else if (m_stop == 1 && tk) begin
                    if (m_drain == DELAY - 1) m_stop = 2;
                    else m_drain++;
                end
                if (tk && !m_halt) begin
                    if (seen == 3'b111) m_armed = 1;
                    else if (m_armed && seen == 3'b011) begin m_halt = 1; m_armed = 0; end
                    else m_armed = 0;
                end
            end
        end
    end

    always @(negedge clk) begin
        if (rst_n) begin
            check("R5 main_en_o vs model", main_en_o, m_stop != 2);
            check("R2 pclk_freeze_o vs model", pclk_freeze_o, m_halt);
            check("R9 osc_run_o vs model", osc_run_o, (m_stop != 2) || mode_i);
            check("R9 gate_en_o vs model", gate_en_o, (m_stop != 2) || !mode_i);
        end
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc == 150000) begin
            total++; bad++;
            $display("FAIL watchdog expired");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    task automatic hold(input logic [2:0] s, input int periods);
        status_i = s;
        repeat (periods * N) @(negedge clk);
    endtask

    task automatic pulse_start();
        start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check("R1 reset main_en_o", main_en_o, 1'b1);
        check("R1 reset pclk_freeze_o", pclk_freeze_o, 1'b0);
        check("R1 reset osc_run_o", osc_run_o, 1'b1);
        check("R1 reset gate_en_o", gate_en_o, 1'b1);
        rst_n = 1'b1;
        @(negedge clk);

        // R3: halt code after non-passive codes
        hold(3'b010, 4);
        hold(3'b011, 6);
        check("R3 stray 011 main_en_o", main_en_o, 1'b1);
        check("R3 stray 011 pclk_freeze_o", pclk_freeze_o, 1'b0);
        hold(3'b111, 3);
        hold(3'b101, 2);
        hold(3'b011, 6);
        check("R3 gap before 011 pclk_freeze_o", pclk_freeze_o, 1'b0);
        check("R3 gap before 011 osc_run_o", osc_run_o, 1'b1);

        // R2, R4, R5, R9: genuine halt in oscillator-stop mode
        mode_i = 1'b0;
        status_i = 3'b111;
        repeat (3 * N) @(negedge clk);
        status_i = 3'b011;
        while (!pclk_freeze_o && cyc < 100000) @(negedge clk);
        check("R4 main_en_o still high at freeze", main_en_o, 1'b1);
        repeat (6 * N) @(negedge clk);
        check("R2 halt froze pclk", pclk_freeze_o, 1'b1);
        check("R5 main_en_o stopped", main_en_o, 1'b0);
        check("R9 mode0 osc_run_o low", osc_run_o, 1'b0);
        check("R9 mode0 gate_en_o high", gate_en_o, 1'b1);

        // R7, R8: start with 011 held, no re-trigger
        pulse_start();
        check("R7 start main_en_o", main_en_o, 1'b1);
        check("R7 start pclk_freeze_o", pclk_freeze_o, 1'b0);
        hold(3'b011, 10);
        check("R8 held 011 no restop", main_en_o, 1'b1);
        check("R8 held 011 no freeze", pclk_freeze_o, 1'b0);

        // R6, R9: stop line alone, clock-gate mode
        mode_i = 1'b1;
        hold(3'b111, 2);
        hold(3'b011, 8);
        check("R6 stop line stops clocks", main_en_o, 1'b0);
        check("R9 mode1 gate_en_o low", gate_en_o, 1'b0);
        check("R9 mode1 osc_run_o high", osc_run_o, 1'b1);

        // R7 with stop line low, R8 re-arm with short passive
        pulse_start();
        check("R7 start with stop low", main_en_o, 1'b1);
        hold(3'b011, 4);
        check("R8 still running before re-arm", main_en_o, 1'b1);
        hold(3'b111, 1);
        hold(3'b011, 8);
        check("R8 re-armed stop", main_en_o, 1'b0);
        check("R8 re-armed freeze", pclk_freeze_o, 1'b1);

        pulse_start();
        hold(3'b111, 4);
        check("R1 run after final start", main_en_o, 1'b1);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule